// File: doc/BRIEF.md
# QBUS Memory Slave Responder

This block sits on the target side of a 16-bit multiplexed, active-low address/data bus of the PDP-11 family. When SYNC is asserted, it takes the address from the AD lines. If the address falls inside a configured window, the block then answers the data strobes that follow, serving them from an internal word array. A DIN strobe is a read: the block drives the stored word onto the bus and asserts RPLY. A DOUT strobe is a write: the block takes the word off the bus, stores it and asserts RPLY. In both cases RPLY is held until the master drops its strobe.

The wired-OR pins are modelled as three separate signals: the line levels coming in, the levels the block would drive, and an output enable. All AD values are in negative logic, so an idle pulled-up bus reads as all ones. The control inputs are asynchronous to the block clock and pass through two-flop synchronizers before the controller sees them. A read-modify-write cycle keeps SYNC low across a read phase followed by a write phase, and both phases use the one latched address.

Top module: `qbus_mem_slave`

## Requirements
- R1: While and right after reset, rply_n is 1, ad_oe is 0 and ad_o is all ones.
- R2: The target address is the bitwise inverse of ad_i, sampled once SYNC assertion is seen. Changes on ad_i while sync_n stays low do not move the target of later phases in the same cycle.
- R3: On a DIN phase at a selected address, the block drives ad_o with the bitwise inverse of the stored word, sets ad_oe to 1 and pulls rply_n low. It holds all three until DIN negation is seen, then returns rply_n to 1 and ad_oe to 0.
- R4: On a DOUT phase at a selected address with wtbt_n high, the block stores the inverse of ad_i as a full word and pulls rply_n low. It releases rply_n only after DOUT negation is seen.
- R5: On a DOUT phase with wtbt_n low, only one byte lane is written. If address bit 0 is 0, bits 7:0 are written from bus bits 7:0. If address bit 0 is 1, bits 15:8 are written from bus bits 15:8. The other byte keeps its value.
- R6: An address is selected when WIN_BASE <= address < WIN_END (defaults 0x1000 and 0x2000). For an unselected address, rply_n stays 1 and ad_oe stays 0 whatever the strobes do, and the array is not changed.
- R7: In a read-modify-write cycle (DIN phase, then DOUT phase, under one SYNC), the block returns the old word and then stores the new word, both at the latched address.
- R8: The block takes a new address only after SYNC negation has been seen. A cycle started right after the previous one ends targets its own address.
- R9: rply_n goes low only in the cycle after a synchronized DIN or DOUT assertion. ad_oe is never 1 while rply_n is 1.
- R10: The word index is (address - WIN_BASE) >> 1, so a read at an odd byte address returns the word at the even address below it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ad_i | input | 16 | Level seen on the multiplexed AD lines (negative logic) |
| ad_o | output | 16 | Level the block drives on the AD lines when enabled |
| ad_oe | output | 1 | Output enable for ad_o |
| sync_n | input | 1 | Cycle framing strobe, active low |
| din_n | input | 1 | Read data strobe, active low |
| dout_n | input | 1 | Write data strobe, active low |
| wtbt_n | input | 1 | Byte-write marker during a write phase, active low |
| rply_n | output | 1 | Reply handshake to the master, active low |

## Verification
The bench probes the window edges at 0x0FFE, 0x1FFE and 0x2000. A decoder with an off-by-one limit would either answer outside the window or go silent on its last word. Byte writes are sent to both lanes in turn. A swapped lane select or a missing byte mask would corrupt the neighbouring byte, and a read-back shows that. Read-modify-write and a re-driven AD bus under a held SYNC are used to catch a controller that re-latches the address or drops back to idle between phases, which would make the second phase hit the wrong word. Every clock, the bench also compares the handshake outputs with its own expectation. A reply that is released early, asserted without a strobe or given to an unselected address shows up at once.

// File: rtl/qbus_pkg.sv
package qbus_pkg;

    localparam int QB_W = 16;
    localparam int QB_LANES = QB_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PHASE = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } qb_state_e;

    typedef struct packed {
        logic                en;
        logic [QB_LANES-1:0] be;
        logic [QB_W-1:0]     data;
    } qb_wr_t;

    // negative-logic bus: value is the inverse of the line level
    function automatic logic [QB_W-1:0] line_to_val(input logic [QB_W-1:0] lv);
        return ~lv;
    endfunction

    function automatic logic [QB_LANES-1:0] lane_mask(input logic byte_op,
                                                      input logic odd);
        if (!byte_op) return '1;
        return odd ? QB_LANES'(2'b10) : QB_LANES'(2'b01);
    endfunction

endpackage

// File: rtl/qbus_sync.sv
module qbus_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) st[i] <= '1;
                else if (i == 0) st[i] <= d;
                else st[i] <= st[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = st[STAGES-1];
endmodule

// File: rtl/qbus_win_dec.sv
module qbus_win_dec
    import qbus_pkg::*;
#(
    parameter logic [QB_W-1:0] WIN_BASE = 16'h1000,
    parameter logic [QB_W-1:0] WIN_END  = 16'h2000,
    parameter int              IDX_W    = 11
) (
    input  logic [QB_W-1:0]  addr,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic [QB_W-1:0] off;

    assign off = addr - WIN_BASE;
    assign hit = (addr >= WIN_BASE) && (addr < WIN_END);
    assign idx = off[IDX_W:1];
endmodule

// File: rtl/qbus_mem.sv
module qbus_mem
    import qbus_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] idx,
    input  qb_wr_t           wr,
    output logic [QB_W-1:0]  rd_word
);
    logic [QB_W-1:0] arr [DEPTH];

    generate
        for (genvar l = 0; l < QB_LANES; l++) begin : g_lane
            always_ff @(posedge clk) begin
                if (wr.en && wr.be[l])
                    arr[idx][l*8 +: 8] <= wr.data[l*8 +: 8];
            end
        end
    endgenerate

    assign rd_word = arr[idx];
endmodule

// File: rtl/qbus_ctrl.sv
module qbus_ctrl
    import qbus_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            sync_a,
    input  logic            din_a,
    input  logic            dout_a,
    input  logic            wtbt_a,
    input  logic [QB_W-1:0] ad_lines,
    input  logic            hit,
    input  logic [QB_W-1:0] rd_word,
    output logic [QB_W-1:0] cyc_addr,
    output qb_wr_t          wr,
    output logic [QB_W-1:0] ad_o,
    output logic            ad_oe,
    output logic            rply_n
);
    qb_state_e st;

    always_comb begin
        wr.en   = (st == ST_PHASE) && sync_a && hit && !din_a && dout_a;
        wr.be   = lane_mask(wtbt_a, cyc_addr[0]);
        wr.data = line_to_val(ad_lines);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cyc_addr <= '0;
            ad_o     <= '1;
            ad_oe    <= 1'b0;
            rply_n   <= 1'b1;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (sync_a) begin
                        cyc_addr <= line_to_val(ad_lines);
                        st       <= ST_PHASE;
                    end
                end
                ST_PHASE: begin
                    if (!sync_a) begin
                        st <= ST_IDLE;
                    end else if (hit && din_a) begin
                        ad_o   <= ~rd_word;
                        ad_oe  <= 1'b1;
                        rply_n <= 1'b0;
                        st     <= ST_READ;
                    end else if (hit && dout_a) begin
                        rply_n <= 1'b0;
                        st     <= ST_WRITE;
                    end
                end
                ST_READ: begin
                    if (!din_a) begin
                        ad_o   <= '1;
                        ad_oe  <= 1'b0;
                        rply_n <= 1'b1;
                        st     <= ST_PHASE;
                    end
                end
                ST_WRITE: begin
                    if (!dout_a) begin
                        rply_n <= 1'b1;
                        st     <= ST_PHASE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/qbus_mem_slave.sv
module qbus_mem_slave
    import qbus_pkg::*;
#(
    parameter logic [QB_W-1:0] WIN_BASE    = 16'h1000,
    parameter logic [QB_W-1:0] WIN_END     = 16'h2000,
    parameter int              SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [QB_W-1:0] ad_i,
    output logic [QB_W-1:0] ad_o,
    output logic            ad_oe,
    input  logic            sync_n,
    input  logic            din_n,
    input  logic            dout_n,
    input  logic            wtbt_n,
    output logic            rply_n
);
    localparam int DEPTH = (int'(WIN_END) - int'(WIN_BASE)) / 2;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [3:0]       strobes_q;
    logic             sync_a, din_a, dout_a, wtbt_a;
    logic [QB_W-1:0]  cyc_addr;
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic [QB_W-1:0]  rd_word;
    qb_wr_t           wr;

    qbus_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sync_n, din_n, dout_n, wtbt_n}),
        .q   (strobes_q)
    );

    assign sync_a = ~strobes_q[3];
    assign din_a  = ~strobes_q[2];
    assign dout_a = ~strobes_q[1];
    assign wtbt_a = ~strobes_q[0];

    qbus_win_dec #(.WIN_BASE(WIN_BASE), .WIN_END(WIN_END), .IDX_W(IDX_W)) u_dec (
        .addr (cyc_addr),
        .hit  (hit),
        .idx  (idx)
    );

    qbus_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
        .clk     (clk),
        .idx     (idx),
        .wr      (wr),
        .rd_word (rd_word)
    );

    qbus_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .sync_a   (sync_a),
        .din_a    (din_a),
        .dout_a   (dout_a),
        .wtbt_a   (wtbt_a),
        .ad_lines (ad_i),
        .hit      (hit),
        .rd_word  (rd_word),
        .cyc_addr (cyc_addr),
        .wr       (wr),
        .ad_o     (ad_o),
        .ad_oe    (ad_oe),
        .rply_n   (rply_n)
    );
endmodule

// File: rtl/qbus_mem_slave_chk.sv
module qbus_mem_slave_chk (
    input logic clk,
    input logic rst,
    input logic ad_oe,
    input logic rply_n,
    input logic din_a,
    input logic dout_a,
    input logic hit
);
    // R9: the bus is only driven while a reply is given
    a_r9_oe_needs_rply: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> !rply_n);

    // R9: a reply starts only after a synchronized strobe
    a_r9_rply_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        $fell(rply_n) |-> $past(din_a || dout_a));

    // R3: read reply and drive are released once DIN is gone
    a_r3_read_release: assert property (@(posedge clk) disable iff (rst)
        (!rply_n && ad_oe && !din_a) |=> (rply_n && !ad_oe));

    // R4: write reply is released once DOUT is gone
    a_r4_write_release: assert property (@(posedge clk) disable iff (rst)
        (!rply_n && !ad_oe && !dout_a) |=> rply_n);

    // R6: no reply for an address outside the window
    a_r6_no_rply_outside: assert property (@(posedge clk) disable iff (rst)
        !rply_n |-> hit);
endmodule

bind qbus_mem_slave qbus_mem_slave_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .ad_oe  (ad_oe),
    .rply_n (rply_n),
    .din_a  (din_a),
    .dout_a (dout_a),
    .hit    (hit)
);

// File: tb/qbus_mem_slave_tb_top.sv
`timescale 1ns/1ps
module qbus_mem_slave_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ad_i = 16'hFFFF;
    logic [15:0] ad_o;
    logic        ad_oe;
    logic        sync_n = 1'b1, din_n = 1'b1, dout_n = 1'b1, wtbt_n = 1'b1;
    logic        rply_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit exp_quiet = 0;
    logic [15:0] cur_addr;
    logic [15:0] model [int];

    always #2 clk = ~clk;

    qbus_mem_slave dut_i (
        .clk(clk), .rst(rst), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
        .sync_n(sync_n), .din_n(din_n), .dout_n(dout_n), .wtbt_n(wtbt_n),
        .rply_n(rply_n)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-clock comparison of handshake outputs against bench expectation
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(!(ad_oe && rply_n), "R9", {14'd0, ad_oe, rply_n}, 16'h0);
            if (exp_quiet)
                check(rply_n && !ad_oe, "R6", {14'd0, ad_oe, rply_n}, 16'h1);
        end
    end

    function automatic bit in_win(input logic [15:0] a);
        return (a >= 16'h1000) && (a < 16'h2000);
    endfunction

    task automatic wait_rply(input logic lvl, output bit seen);
        seen = 0;
        for (int i = 0; i < 16 && !seen; i++) begin
            @(negedge clk);
            if (rply_n == lvl) seen = 1;
        end
    endtask

    task automatic start_cycle(input logic [15:0] a);
        @(negedge clk);
        cur_addr = a;
        ad_i = ~a;
        sync_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic end_cycle();
        sync_n = 1'b1;
        ad_i = 16'hFFFF;
        repeat (4) @(negedge clk);
        check(rply_n && !ad_oe, "R8", {14'd0, ad_oe, rply_n}, 16'h1);
    endtask

    task automatic rd_phase(input string req);
        bit seen;
        logic [15:0] exp;
        int k;
        k = int'(cur_addr >> 1);
        exp = model.exists(k) ? model[k] : 16'h0000;
        ad_i = 16'hFFFF;
        if (in_win(cur_addr)) begin
            din_n = 1'b0;
            wait_rply(1'b0, seen);
            check(seen && ad_oe && (ad_o == ~exp), req, ~ad_o, exp);
            din_n = 1'b1;
            wait_rply(1'b1, seen);
            check(seen && !ad_oe, "R3", {14'd0, ad_oe, rply_n}, 16'h1);
        end else begin
            exp_quiet = 1;
            din_n = 1'b0;
            repeat (12) @(negedge clk);
            check(rply_n && !ad_oe, "R6", {14'd0, ad_oe, rply_n}, 16'h1);
            din_n = 1'b1;
            repeat (4) @(negedge clk);
            exp_quiet = 0;
        end
    endtask

    task automatic wr_phase(input logic [15:0] d, input bit byte_op, input string req);
        bit seen;
        int k;
        k = int'(cur_addr >> 1);
        ad_i = ~d;
        wtbt_n = ~byte_op;
        if (in_win(cur_addr)) begin
            dout_n = 1'b0;
            wait_rply(1'b0, seen);
            check(seen, req, {15'd0, rply_n}, 16'h0);
            repeat (3) @(negedge clk);
            check(!rply_n, "R4", {15'd0, rply_n}, 16'h0);
            dout_n = 1'b1;
            wait_rply(1'b1, seen);
            check(seen, "R4", {15'd0, rply_n}, 16'h1);
            if (!model.exists(k)) model[k] = 16'h0000;
            if (!byte_op) model[k] = d;
            else if (cur_addr[0]) model[k][15:8] = d[15:8];
            else model[k][7:0] = d[7:0];
        end else begin
            exp_quiet = 1;
            dout_n = 1'b0;
            repeat (12) @(negedge clk);
            check(rply_n, "R6", {15'd0, rply_n}, 16'h1);
            dout_n = 1'b1;
            repeat (4) @(negedge clk);
            exp_quiet = 0;
        end
        ad_i = 16'hFFFF;
        wtbt_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check(rply_n && !ad_oe && ad_o == 16'hFFFF, "R1", ad_o, 16'hFFFF);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(rply_n && !ad_oe, "R1", {14'd0, ad_oe, rply_n}, 16'h1);

        // R4 word write, R3 read back
        start_cycle(16'h1000); wr_phase(16'h1234, 0, "R4"); end_cycle();
        start_cycle(16'h1000); rd_phase("R3"); end_cycle();
        // R6 last word inside window
        start_cycle(16'h1FFE); wr_phase(16'hBEEF, 0, "R6"); end_cycle();
        start_cycle(16'h1FFE); rd_phase("R6"); end_cycle();
        // R10 odd byte address reads the even word
        start_cycle(16'h1001); rd_phase("R10"); end_cycle();
        // R6 outside window: above and below
        start_cycle(16'h2000); wr_phase(16'hDEAD, 0, "R6"); end_cycle();
        start_cycle(16'h0FFE); rd_phase("R6"); end_cycle();
        start_cycle(16'h1FFE); rd_phase("R6"); end_cycle();
        // R5 byte lanes
        start_cycle(16'h1000); wr_phase(16'hEEAB, 1, "R5"); end_cycle();
        start_cycle(16'h1000); rd_phase("R5"); end_cycle();
        start_cycle(16'h1001); wr_phase(16'hCD77, 1, "R5"); end_cycle();
        start_cycle(16'h1000); rd_phase("R5"); end_cycle();
        // R7 read-modify-write under one SYNC
        start_cycle(16'h1FFE); rd_phase("R7"); wr_phase(16'h5555, 0, "R7"); end_cycle();
        start_cycle(16'h1FFE); rd_phase("R7"); end_cycle();
        // R2 address change under held SYNC is ignored
        start_cycle(16'h1002); wr_phase(16'hA5C3, 0, "R2");
        ad_i = ~16'h1FFE;
        repeat (4) @(negedge clk);
        rd_phase("R2"); end_cycle();
        start_cycle(16'h1FFE); rd_phase("R2"); end_cycle();
        // R8 back-to-back cycles with different addresses
        start_cycle(16'h1004); wr_phase(16'h0F0F, 0, "R8");
        sync_n = 1'b1; ad_i = 16'hFFFF;
        repeat (3) @(negedge clk);
        start_cycle(16'h1002); rd_phase("R8"); end_cycle();
        start_cycle(16'h1004); rd_phase("R8"); end_cycle();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule